// File: doc/BRIEF.md
# VPW Frame Transmitter

This block turns a stream of host bytes into a variable-pulse-width serial frame on a single drive line. It opens a message with a long active start-of-frame pulse. For an in-frame response it opens instead with a normalization pulse, which it sends only once the receive side reports end-of-data. It then sends every byte, most significant bit first, as eight symbols whose level alternates. After the byte the host marks as last, it appends a CRC byte when the frame type calls for one. Symbol timing counts a 2 MHz tick, which is produced from the system clock by a selectable divider.

A serial controller starts a frame by offering the first byte while the transmitter is idle. The controller then keeps a one-byte holding register full. A one-cycle `byte_sent` strobe follows the final symbol of every byte, including the CRC byte, and tells the controller to offer the next byte. If no byte is waiting when the current one finishes, the frame is cut short without a CRC.

Top module: `vpw_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `vpw_out` is 0 (passive) and `byte_sent` is 0.
- R2: A byte offered while idle with `frame_kind` = 0 (message) starts a frame. `vpw_out` goes to 1 from the next clock edge for SOF_T ticks, and the first data symbol follows at once.
- R3: Data bits go out most significant bit first, one symbol per bit. The first data symbol is passive (0), and each symbol after it takes the opposite level. A passive symbol is LONG_T ticks for a 1 and SHORT_T ticks for a 0. An active symbol is SHORT_T ticks for a 1 and LONG_T ticks for a 0.
- R4: For `frame_kind` 0 (message) and 3 (multi-byte response), the byte flagged by `byte_last` is followed by a CRC byte. The CRC uses the polynomial 0x1D (x^8+x^4+x^3+x^2+1), starts from 0xFF, runs MSB first over every data byte of the frame, and is sent inverted.
- R5: For `frame_kind` 1 and 2 (single-byte responses), the frame ends after the flagged byte, with no CRC.
- R6: A response frame (`frame_kind` 1, 2 or 3) opens with an active normalization pulse instead of the start-of-frame pulse. The pulse is SHORT_T ticks for kinds 1 and 2 and LONG_T ticks for kind 3.
- R7: While idle, a byte offered with a response kind and `eod_seen` = 0 is ignored. No frame starts and the line stays passive.
- R8: `byte_sent` is high for exactly one clock, in the cycle after the clock edge that ends the final symbol of each data byte and of the CRC byte.
- R9: If the holding register is empty when a byte that is not flagged last finishes, the frame ends there. No CRC is sent and the line returns to passive.
- R10: `div_sel` sets the tick rate: 0 gives a tick every clock, 1 every 2 clocks, 2 every 4 clocks and 3 every 6 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 2 | Clock divide select for the symbol tick |
| byte_valid | input | 1 | One-cycle offer of a byte |
| byte_data | input | 8 | Offered byte |
| byte_last | input | 1 | Offered byte is the last of its message or response |
| frame_kind | input | 2 | 0 message, 1 and 2 single-byte response, 3 multi-byte response |
| eod_seen | input | 1 | Receive side has seen end-of-data |
| vpw_out | output | 1 | Bus drive line, 1 = active |
| byte_sent | output | 1 | One-cycle strobe after each byte's final symbol |

## Verification
The bench compares the line against a cycle-exact expected waveform for messages and for all three response kinds. A design that swapped the two level rules, started data on an active symbol or sent bits in the wrong order would go wrong within the first byte. A CRC with the wrong preset, a missing inversion or a CRC left off a multi-byte response shows up in the final byte. Normalization pulses of the wrong length, or a CRC tacked onto a single-byte response, break the waveform at the start or the end of the frame. Further tests cover an empty holding register, a response offered before end-of-data, and a divided tick. A design that waited for a missing byte, started a response too early or ignored the divider would be caught there.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

  typedef enum logic [1:0] {
    KIND_MSG  = 2'd0,
    KIND_IFR1 = 2'd1,
    KIND_IFR2 = 2'd2,
    KIND_IFR3 = 2'd3
  } frame_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SOF,
    ST_NB,
    ST_DATA
  } tx_state_e;

  localparam logic [7:0] CRC_POLY   = 8'h1D;
  localparam logic [7:0] CRC_PRESET = 8'hFF;

  // One byte of CRC-8, MSB first, whole byte folded in before shifting
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc, input logic [7:0] data);
    logic [7:0] c;
    c = crc ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

  // A symbol is long when the bit value differs from the line level
  function automatic logic sym_is_long(input logic bit_val, input logic active);
    return bit_val ^ active;
  endfunction

  function automatic logic kind_has_crc(input frame_kind_e k);
    return (k == KIND_MSG) || (k == KIND_IFR3);
  endfunction

  function automatic logic nb_is_long(input frame_kind_e k);
    return k == KIND_IFR3;
  endfunction

  // Terminal count of the tick divider for each divide select
  function automatic logic [2:0] div_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd3;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/vpw_tick_gen.sv
module vpw_tick_gen
  import vpw_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int DW = 3;

  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;

  always_comb begin
    lim  = div_limit(div_sel);
    tick = (cnt >= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vpw_sym_timer.sv
module vpw_sym_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          sym_end
);
  logic [CW-1:0] cnt;

  // The symbol closes on the tick that finds one count left
  assign sym_end = tick && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (load)                   cnt <= load_val;
    else if (tick && (cnt != '0))    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/vpw_crc_acc.sv
module vpw_crc_acc
  import vpw_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       upd,
  input  logic [7:0] data,
  output logic [7:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= CRC_PRESET;
    else if (init) crc <= crc8_byte(CRC_PRESET, data);
    else if (upd)  crc <= crc8_byte(crc, data);
  end
endmodule

// File: rtl/vpw_frame_tx.sv
module vpw_frame_tx
  import vpw_tx_pkg::*;
#(
  parameter int SHORT_T = 128,
  parameter int LONG_T  = 256,
  parameter int SOF_T   = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       byte_last,
  input  logic [1:0] frame_kind,
  input  logic       eod_seen,
  output logic       vpw_out,
  output logic       byte_sent
);
  localparam int MAX_T = (SOF_T > LONG_T) ? SOF_T : LONG_T;
  localparam int CW    = $clog2(MAX_T + 1);

  tx_state_e   state;
  frame_kind_e kind_q;
  frame_kind_e kind_in;
  logic [7:0]  cur_byte;
  logic        cur_last;
  logic        in_crc;
  logic [2:0]  bit_idx;
  logic        phase;
  logic [7:0]  hold_byte;
  logic        hold_last;
  logic        hold_full;
  logic        vpw_q;
  logic        sent_q;

  // Named internal events
  logic          tick;
  logic          sym_end;
  logic          start_evt;
  logic          byte_end;
  logic          head_end;
  logic          frame_end;
  logic          idle;
  logic          in_data;
  logic          crc_due;
  logic          next_avail;
  logic          pop_hold;
  logic          hold_take;
  logic          nbit;
  logic [7:0]    next_byte;
  logic [7:0]    crc_val;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;

  function automatic logic [CW-1:0] sym_len(input logic b, input logic act);
    return sym_is_long(b, act) ? CW'(LONG_T) : CW'(SHORT_T);
  endfunction

  vpw_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .tick    (tick)
  );

  vpw_sym_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (tmr_load),
    .load_val (tmr_val),
    .sym_end  (sym_end)
  );

  vpw_crc_acc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (start_evt),
    .upd   (pop_hold),
    .data  (start_evt ? byte_data : hold_byte),
    .crc   (crc_val)
  );

  always_comb begin
    idle       = (state == ST_IDLE);
    in_data    = (state == ST_DATA);
    kind_in    = frame_kind_e'(frame_kind);
    start_evt  = idle && byte_valid && ((kind_in == KIND_MSG) || eod_seen);
    head_end   = ((state == ST_SOF) || (state == ST_NB)) && sym_end;
    byte_end   = in_data && sym_end && (bit_idx == 3'd7);
    crc_due    = cur_last && !in_crc && kind_has_crc(kind_q);
    next_avail = !in_crc && (crc_due || (!cur_last && hold_full));
    next_byte  = crc_due ? ~crc_val : hold_byte;
    pop_hold   = byte_end && !in_crc && !cur_last && hold_full;
    frame_end  = byte_end && !next_avail;
    hold_take  = !idle && byte_valid && !cur_last && !in_crc
                 && (!hold_full || pop_hold) && !(pop_hold && hold_last);
    nbit       = byte_end ? next_byte[7] : cur_byte[3'd6 - bit_idx];

    tmr_load = 1'b0;
    tmr_val  = '0;
    if (start_evt) begin
      tmr_load = 1'b1;
      if (kind_in == KIND_MSG)   tmr_val = CW'(SOF_T);
      else if (nb_is_long(kind_in)) tmr_val = CW'(LONG_T);
      else                       tmr_val = CW'(SHORT_T);
    end else if (head_end) begin
      tmr_load = 1'b1;
      tmr_val  = sym_len(cur_byte[7], 1'b0);
    end else if (in_data && sym_end && !frame_end) begin
      tmr_load = 1'b1;
      tmr_val  = sym_len(nbit, ~phase);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind_q    <= KIND_MSG;
      cur_byte  <= '0;
      cur_last  <= 1'b0;
      in_crc    <= 1'b0;
      bit_idx   <= '0;
      phase     <= 1'b0;
      hold_byte <= '0;
      hold_last <= 1'b0;
      hold_full <= 1'b0;
      vpw_q     <= 1'b0;
      sent_q    <= 1'b0;
    end else begin
      sent_q <= byte_end;

      if (hold_take) begin
        hold_byte <= byte_data;
        hold_last <= byte_last;
        hold_full <= 1'b1;
      end else if (pop_hold) begin
        hold_full <= 1'b0;
      end

      if (start_evt) begin
        state     <= (kind_in == KIND_MSG) ? ST_SOF : ST_NB;
        kind_q    <= kind_in;
        cur_byte  <= byte_data;
        cur_last  <= byte_last;
        in_crc    <= 1'b0;
        hold_full <= 1'b0;
        bit_idx   <= '0;
        phase     <= 1'b0;
        vpw_q     <= 1'b1;
      end else if (head_end) begin
        state   <= ST_DATA;
        bit_idx <= '0;
        phase   <= 1'b0;
        vpw_q   <= 1'b0;
      end else if (in_data && sym_end) begin
        if (frame_end) begin
          state     <= ST_IDLE;
          vpw_q     <= 1'b0;
          in_crc    <= 1'b0;
          cur_last  <= 1'b0;
          hold_full <= 1'b0;
        end else begin
          phase   <= ~phase;
          vpw_q   <= ~phase;
          bit_idx <= bit_idx + 1'b1;
          if (byte_end) begin
            cur_byte <= next_byte;
            if (crc_due) in_crc   <= 1'b1;
            else         cur_last <= hold_last;
          end
        end
      end
    end
  end

  assign vpw_out   = vpw_q;
  assign byte_sent = sent_q;

endmodule

// File: rtl/vpw_frame_tx_chk.sv
module vpw_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] div_sel,
  input logic       tick,
  input logic       sym_end,
  input logic       start_evt,
  input logic       idle,
  input logic       byte_valid,
  input logic [1:0] frame_kind,
  input logic       eod_seen,
  input logic       vpw_out,
  input logic       byte_sent
);
  assert_idle_passive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !vpw_out);

  assert_frame_opens_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> vpw_out);

  assert_line_moves_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vpw_out != $past(vpw_out)) |-> ($past(sym_end) || $past(start_evt)));

  assert_ifr_waits_eod_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && byte_valid && (frame_kind != 2'd0) && !eod_seen) |=> idle);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sent |=> !byte_sent);

  assert_strobe_after_symbol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sent |-> $past(sym_end));

  assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_sel != 2'd0) && $stable(div_sel)) |=> !tick);
endmodule

bind vpw_frame_tx vpw_frame_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_sel    (div_sel),
  .tick       (tick),
  .sym_end    (sym_end),
  .start_evt  (start_evt),
  .idle       (idle),
  .byte_valid (byte_valid),
  .frame_kind (frame_kind),
  .eod_seen   (eod_seen),
  .vpw_out    (vpw_out),
  .byte_sent  (byte_sent)
);

// File: tb/vpw_frame_tx_tb.sv
module vpw_frame_tx_tb;
  localparam int SHORT = 3;
  localparam int LONG  = 6;
  localparam int SOF   = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       byte_last = 1'b0;
  logic [1:0] frame_kind = 2'd0;
  logic       eod_seen = 1'b0;
  logic       vpw_out;
  logic       byte_sent;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic exp_lvl [0:1023];
  logic exp_snt [0:1023];
  int   exp_n;

  // {kind[2], byte count[3], expect crc, expect long nb, four bytes}
  localparam logic [38:0] VEC [0:5] = '{
    {2'd0, 3'd3, 1'b1, 1'b0, 32'h686AF100},
    {2'd0, 3'd1, 1'b1, 1'b0, 32'h00000000},
    {2'd0, 3'd4, 1'b1, 1'b0, 32'hFF55AA81},
    {2'd1, 3'd1, 1'b0, 1'b0, 32'h5A000000},
    {2'd2, 3'd1, 1'b0, 1'b0, 32'hC3000000},
    {2'd3, 3'd2, 1'b1, 1'b1, 32'h12340000}
  };

  vpw_frame_tx #(.SHORT_T(SHORT), .LONG_T(LONG), .SOF_T(SOF)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_last(byte_last), .frame_kind(frame_kind),
    .eod_seen(eod_seen), .vpw_out(vpw_out), .byte_sent(byte_sent)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add_sym(input logic lvl, input int len);
    for (int j = 0; j < len; j++) begin
      exp_lvl[exp_n] = lvl;
      exp_n++;
    end
  endtask

  // Expected line, sample by sample, built straight from the requirements
  task automatic build_exp(input logic [1:0] kind, input int nb, input logic [31:0] bv,
                           input logic crc_on, input logic nbl);
    logic [7:0] c;
    logic [7:0] b;
    int s;
    logic act;
    logic lg;
    for (int j = 0; j < 1024; j++) begin
      exp_lvl[j] = 1'b0;
      exp_snt[j] = 1'b0;
    end
    exp_n = 0;
    if (kind == 2'd0) add_sym(1'b1, SOF);
    else              add_sym(1'b1, nbl ? LONG : SHORT);
    c = 8'hFF;
    s = 0;
    for (int i = 0; i < nb + (crc_on ? 1 : 0); i++) begin
      if (i < nb) begin
        b = bv[31 - 8*i -: 8];
        for (int t = 7; t >= 0; t--) begin
          c = {c[6:0], 1'b0} ^ ((c[7] ^ b[t]) ? 8'h1D : 8'h00);
        end
      end else begin
        b = ~c;
      end
      for (int t = 7; t >= 0; t--) begin
        act = s[0];
        lg  = act ? !b[t] : b[t];
        add_sym(act, lg ? LONG : SHORT);
        s++;
      end
      exp_snt[exp_n] = 1'b1;
    end
  endtask

  task automatic run_frame(input logic [1:0] kind, input int nb, input logic [31:0] bv,
                           input logic crc_on, input logic nbl, input logic mark_last,
                           input string req);
    int fi;
    int bad_l;
    int bad_s;
    int first_k;
    logic el;
    logic es;
    build_exp(kind, nb, bv, crc_on, nbl);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = bv[31:24];
    byte_last  = mark_last && (nb == 1);
    frame_kind = kind;
    eod_seen   = (kind != 2'd0);
    fi = 1; bad_l = 0; bad_s = 0; first_k = -1;
    for (int k = 0; k < exp_n + 8; k++) begin
      @(negedge clk);
      byte_valid = 1'b0;
      el = (k < exp_n) ? exp_lvl[k] : 1'b0;
      es = exp_snt[k];
      if (vpw_out !== el) begin
        if (bad_l == 0) first_k = k;
        bad_l++;
      end
      if (byte_sent !== es) bad_s++;
      if (((k == 0) || es) && (fi < nb)) begin
        byte_valid = 1'b1;
        byte_data  = bv[31 - 8*fi -: 8];
        byte_last  = mark_last && (fi == nb - 1);
        fi++;
      end
    end
    eod_seen = 1'b0;
    check(bad_l == 0, req, $sformatf("line mismatches (first at sample %0d)", first_k), bad_l, 0);
    check(bad_s == 0, "R8", "byte_sent mismatches", bad_s, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int hi;
    int st;
    int first_e;
    int got;
    repeat (4) @(negedge clk);
    check(vpw_out == 1'b0, "R1", "line during reset", vpw_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vpw_out == 1'b0, "R1", "line after reset", vpw_out, 0);
    check(byte_sent == 1'b0, "R1", "strobe after reset", byte_sent, 0);

    // Vector table: R2 R3 R4 message frames, R5 R6 short responses, R4 R6 multi-byte response
    for (int v = 0; v < 6; v++) begin
      run_frame(VEC[v][38:37], int'(VEC[v][36:34]), VEC[v][31:0], VEC[v][33], VEC[v][32], 1'b1,
                (VEC[v][38:37] == 2'd0) ? "R2/R3/R4" :
                (VEC[v][38:37] == 2'd3) ? "R4/R6" : "R5/R6");
      repeat (3) @(negedge clk);
    end

    // R7: response before end-of-data is dropped
    @(negedge clk);
    byte_valid = 1'b1; byte_data = 8'h5A; byte_last = 1'b1; frame_kind = 2'd1; eod_seen = 1'b0;
    @(negedge clk);
    byte_valid = 1'b0;
    hi = 0; st = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (vpw_out) hi++;
      if (byte_sent) st++;
    end
    check(hi == 0, "R7", "active samples without eod", hi, 0);
    check(st == 0, "R7", "strobes without eod", st, 0);
    run_frame(2'd0, 1, 32'h3C000000, 1'b1, 1'b0, 1'b1, "R7 follow-up message");

    // R9: byte not flagged last and nothing waiting
    run_frame(2'd0, 1, 32'h0F000000, 1'b0, 1'b0, 1'b0, "R9");
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (vpw_out || byte_sent) hi++;
    end
    check(hi == 0, "R9", "activity after cut-short frame", hi, 0);

    // R10: divide by two stretches every symbol
    @(negedge clk);
    div_sel = 2'd1;
    build_exp(2'd0, 1, 32'h00000000, 1'b1, 1'b0);
    first_e = -1;
    for (int j = 0; j < 1024; j++) if (exp_snt[j] && first_e < 0) first_e = j;
    @(negedge clk);
    byte_valid = 1'b1; byte_data = 8'h00; byte_last = 1'b1; frame_kind = 2'd0;
    got = -1;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      byte_valid = 1'b0;
      if (byte_sent && got < 0) got = k;
    end
    check((got >= 2*first_e - 2) && (got <= 2*first_e + 1), "R10",
          "first strobe sample with div_sel=1", got, 2*first_e);
    check(vpw_out == 1'b0, "R10", "line after divided frame", vpw_out, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule